// File: doc/BRIEF.md
# Hot-plug slot control and status register block

This block holds the two 16-bit slot registers of a hot-plug capable downstream port: the command register that software writes to steer the slot, and the status register that collects hot-plug events. Software reaches both through one 32-bit config word. The command register sits in the low half and the status register in the high half, and each byte is gated by its own byte enable. Event inputs report a button press, a card insertion or removal request, and a card that is already present at power-up.

The block works out whether the enabled events call for software attention. In legacy interrupt mode it drives a level interrupt. In message mode it sends a one-cycle message pulse with a 5-bit vector each time that decision flips. Each write to the command register is a command that completes at once. An interlock command bit is never stored: a 1 written to it toggles the interlock state, and while the interlock is engaged, insertion and removal requests are refused.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset the word reads 0x0000_03C0. Command bits 9:8 (power indicator) and 7:6 (attention indicator) hold 2'b11, meaning off. Every other command bit and every status bit reads 0. `intx` and `msg_pulse` are low.
- R2: The writable command bits are 0 (button event enable), 3 (presence-change enable), 4 (command-done enable), 5 (hot-plug interrupt enable), 7:6 and 9:8. `wr_be[0]` gates bits 7:0 and `wr_be[1]` gates bits 15:8. All other command bits read 0.
- R3: A write with `wr_be[0]` or `wr_be[1]` set is one command. It sets status bit 4 (command done), which reads back from the next cycle.
- R4: Writing 1 to command bit 11 under `wr_be[1]` toggles status bit 7 (interlock engaged). Command bit 11 always reads 0.
- R5: Status bits 0 (button pressed), 3 (presence changed) and 4 (command done) are write-1-to-clear. `wr_be[2]` gates status bits 7:0 and `wr_be[3]` gates bits 15:8. Writes never change status bits 6 and 7.
- R6: The notify condition is true when command bit 5 is set and some status bit 0, 3 or 4 is set together with its enable in the command bit of the same position. When the condition changes and `msix_en` or `msi_en` is high, `msg_pulse` is high for one cycle from the next edge. It carries `msg_vec` = `vec_in`, and `msg_msix` = 1 if `msix_en` is high, otherwise 0.
- R7: No message is sent while the condition keeps its value. This includes an event whose status bit is already set.
- R8: With both message enables low, `intx` follows the condition. In that mode a status write that leaves the condition false drops `intx`. With a message mode enabled, `intx` is left alone.
- R9: A status write that turns the condition false sends no message.
- R10: An accepted `plug_req` sets status bit 6 (card present) to `plug_insert` and sets status bit 3.
- R11: A `plug_req` that arrives while status bit 7 is set changes no status bit and raises `plug_busy` for one cycle from the next edge.
- R12: `boot_present` sets status bit 6 without setting bit 3, even while the interlock is engaged.
- R13: In a write that enables bytes of both registers, the status clear is applied before the command. A write with no byte enable changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Config write strobe |
| wr_be | input | 4 | Byte enables: [1:0] command, [3:2] status |
| wr_data | input | 32 | Write data, {status, command} |
| rd_data | output | 32 | Read data, {status, command} |
| btn_press | input | 1 | Attention button event |
| plug_req | input | 1 | Insertion or removal request |
| plug_insert | input | 1 | 1 = insertion, 0 = removal |
| boot_present | input | 1 | Card present at power-up |
| plug_busy | output | 1 | Request refused, interlock engaged |
| msi_en | input | 1 | Message mode enabled |
| msix_en | input | 1 | Extended message mode enabled, takes priority |
| vec_in | input | VEC_W | Interrupt message number |
| intx | output | 1 | Level interrupt |
| msg_pulse | output | 1 | One-cycle message request |
| msg_msix | output | 1 | Message goes out as extended message |
| msg_vec | output | VEC_W | Vector of the message |

## Verification
A stale held notify flag shows at the ports in one of three ways: a message pulse with no change in the enabled events, a missing pulse where one is due, or an `intx` level that differs from the condition the bench computes from the read-back registers. Each of these appears one cycle after the write or event. A wrong ordering between the status clear and the command shows in a single combined write. Done in the correct order, that write leaves command-done set and sends a message. Done in the wrong order, it clears command-done and stays silent. A wrong interlock state shows as a missing or spurious `plug_busy` on the next request.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W = 16;

  // command register bit positions
  localparam int C_BTN_EN  = 0;
  localparam int C_PDC_EN  = 3;
  localparam int C_CC_EN   = 4;
  localparam int C_IRQ_EN  = 5;
  localparam int C_LOCK    = 11;

  // status register bit positions
  localparam int S_BTN  = 0;
  localparam int S_PDC  = 3;
  localparam int S_CC   = 4;
  localparam int S_PRES = 6;
  localparam int S_LOCK = 7;

  localparam logic [REG_W-1:0] CTL_WMASK = 16'h03F9;
  localparam logic [REG_W-1:0] CTL_RESET = 16'h03C0;
  localparam logic [REG_W-1:0] EVT_MASK  = 16'h0019;

  // expand a byte-enable pair into a bit mask over one register
  function automatic logic [REG_W-1:0] be_mask(input logic [1:0] be);
    be_mask = {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // event bits line up with their enables at the same positions
  function automatic logic notify_cond(input logic [REG_W-1:0] ctl,
                                       input logic [REG_W-1:0] sta);
    notify_cond = ctl[C_IRQ_EN] && (|(ctl & sta & EVT_MASK));
  endfunction

  function automatic logic [REG_W-1:0] w1c_apply(input logic [REG_W-1:0] sta,
                                                 input logic [REG_W-1:0] data,
                                                 input logic [1:0]       be);
    w1c_apply = sta & ~(data & EVT_MASK & be_mask(be));
  endfunction

  function automatic logic [REG_W-1:0] ctl_merge(input logic [REG_W-1:0] old,
                                                 input logic [REG_W-1:0] data,
                                                 input logic [1:0]       be);
    logic [REG_W-1:0] m;
    m = be_mask(be) & CTL_WMASK;
    ctl_merge = (old & ~m) | (data & m);
  endfunction
endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_be,
  input  logic [2*REG_W-1:0] wr_data,
  input  logic             btn_press,
  input  logic             plug_req,
  input  logic             plug_insert,
  input  logic             boot_present,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] sta_q,
  output logic             sta_wr,
  output logic             cond_after_clr,
  output logic             cond_next,
  output logic             plug_busy
);
  logic             ctl_wr;
  logic             lock_cmd;
  logic             locked;
  logic             plug_ok;
  logic [REG_W-1:0] sta_clr;
  logic [REG_W-1:0] sta_nxt;
  logic [REG_W-1:0] ctl_nxt;

  assign sta_wr   = wr_en && (|wr_be[3:2]);
  assign ctl_wr   = wr_en && (|wr_be[1:0]);
  assign lock_cmd = ctl_wr && wr_be[1] && wr_data[C_LOCK];
  assign locked   = sta_q[S_LOCK];
  assign plug_ok  = plug_req && !locked;

  // step 1: status clear
  assign sta_clr = sta_wr ? w1c_apply(sta_q, wr_data[2*REG_W-1:REG_W], wr_be[3:2])
                          : sta_q;
  assign cond_after_clr = notify_cond(ctl_q, sta_clr);

  // step 2: command, step 3: events
  assign ctl_nxt = ctl_wr ? ctl_merge(ctl_q, wr_data[REG_W-1:0], wr_be[1:0]) : ctl_q;

  always_comb begin
    sta_nxt = sta_clr;
    if (lock_cmd) sta_nxt[S_LOCK] = ~sta_nxt[S_LOCK];
    if (ctl_wr)   sta_nxt[S_CC]   = 1'b1;
    if (btn_press) sta_nxt[S_BTN] = 1'b1;
    if (plug_ok) begin
      sta_nxt[S_PRES] = plug_insert;
      sta_nxt[S_PDC]  = 1'b1;
    end
    if (boot_present) sta_nxt[S_PRES] = 1'b1;
  end

  assign cond_next = notify_cond(ctl_nxt, sta_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= CTL_RESET;
      sta_q     <= '0;
      plug_busy <= 1'b0;
    end else begin
      ctl_q     <= ctl_nxt;
      sta_q     <= sta_nxt;
      plug_busy <= plug_req && locked;
    end
  end

  // R3: a command always leaves command-done set
  p_cmd_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> sta_q[S_CC]);

  // R4: the interlock command flips the interlock state
  p_lock_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_cmd |=> (sta_q[S_LOCK] != $past(sta_q[S_LOCK])));

  // R11: a refusal is only given while locked
  p_busy_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    plug_busy |-> $past(locked && plug_req));

  // R11: a refused request leaves the change bit alone
  p_busy_no_pdc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (plug_req && locked && !ctl_wr && !sta_wr && !boot_present && !btn_press)
      |=> $stable(sta_q));
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify #(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sta_wr,
  input  logic             cond_after_clr,
  input  logic             cond_next,
  input  logic             msi_en,
  input  logic             msix_en,
  input  logic [VEC_W-1:0] vec_in,
  output logic             intx,
  output logic             msg_pulse,
  output logic             msg_msix,
  output logic [VEC_W-1:0] msg_vec
);
  logic notified_q;
  logic base_flag;
  logic change;
  logic msg_mode;

  // a status write updates the held flag silently before the compare
  assign base_flag = sta_wr ? cond_after_clr : notified_q;
  assign change    = cond_next != base_flag;
  assign msg_mode  = msi_en || msix_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      notified_q <= 1'b0;
      intx       <= 1'b0;
      msg_pulse  <= 1'b0;
      msg_msix   <= 1'b0;
      msg_vec    <= '0;
    end else begin
      notified_q <= cond_next;
      msg_pulse  <= change && msg_mode;
      msg_msix   <= msix_en;
      msg_vec    <= vec_in;
      if (!msg_mode) begin
        if (change)                       intx <= cond_next;
        else if (sta_wr && !cond_after_clr) intx <= 1'b0;
      end
    end
  end

  // R6: a message only goes out in a message mode
  p_msg_needs_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse |-> $past(msg_mode));

  // R6: a change in message mode is always announced
  p_msg_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_mode && change) |=> msg_pulse);

  // R7: no change, no message
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !change |=> !msg_pulse);

  // R8: level mode tracks the condition
  p_intx_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_mode && change) |=> (intx == $past(cond_next)));

  // R8: message mode leaves the level alone
  p_intx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |=> (intx == $past(intx)));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             btn_press,
  input  logic             plug_req,
  input  logic             plug_insert,
  input  logic             boot_present,
  output logic             plug_busy,
  input  logic             msi_en,
  input  logic             msix_en,
  input  logic [VEC_W-1:0] vec_in,
  output logic             intx,
  output logic             msg_pulse,
  output logic             msg_msix,
  output logic [VEC_W-1:0] msg_vec
);
  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] sta_q;
  logic             sta_wr;
  logic             cond_after_clr;
  logic             cond_next;

  hp_slot_regs u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_be          (wr_be),
    .wr_data        (wr_data),
    .btn_press      (btn_press),
    .plug_req       (plug_req),
    .plug_insert    (plug_insert),
    .boot_present   (boot_present),
    .ctl_q          (ctl_q),
    .sta_q          (sta_q),
    .sta_wr         (sta_wr),
    .cond_after_clr (cond_after_clr),
    .cond_next      (cond_next),
    .plug_busy      (plug_busy)
  );

  hp_slot_notify #(.VEC_W(VEC_W)) u_notify (
    .clk            (clk),
    .rst_n          (rst_n),
    .sta_wr         (sta_wr),
    .cond_after_clr (cond_after_clr),
    .cond_next      (cond_next),
    .msi_en         (msi_en),
    .msix_en        (msix_en),
    .vec_in         (vec_in),
    .intx           (intx),
    .msg_pulse      (msg_pulse),
    .msg_msix       (msg_msix),
    .msg_vec        (msg_vec)
  );

  assign rd_data = {sta_q, ctl_q};

  // R4: the interlock command bit never reads back as 1
  p_lock_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && wr_data[C_LOCK]) |=> !rd_data[C_LOCK]);
endmodule

// File: tb/sim_hp_slot_ctrl.sv
`timescale 1ns/1ps
module sim_hp_slot_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        btn_press = 1'b0, plug_req = 1'b0, plug_insert = 1'b0, boot_present = 1'b0;
  logic        plug_busy;
  logic        msi_en = 1'b0, msix_en = 1'b0;
  logic [4:0]  vec_in = 5'd0;
  logic        intx, msg_pulse, msg_msix;
  logic [4:0]  msg_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hp_slot_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .btn_press(btn_press), .plug_req(plug_req),
    .plug_insert(plug_insert), .boot_present(boot_present), .plug_busy(plug_busy),
    .msi_en(msi_en), .msix_en(msix_en), .vec_in(vec_in), .intx(intx),
    .msg_pulse(msg_pulse), .msg_msix(msg_msix), .msg_vec(msg_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_be = '0; wr_data = '0;
  endtask

  task automatic ev(input logic b, input logic p, input logic ins, input logic boot);
    @(negedge clk); btn_press = b; plug_req = p; plug_insert = ins; boot_present = boot;
    @(negedge clk); btn_press = 0; plug_req = 0; plug_insert = 0; boot_present = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 word", rd_data, 32'h0000_03C0);
    chk("R1 intx", {31'd0, intx}, 0);
    chk("R1 msg", {31'd0, msg_pulse}, 0);
  endtask

  task automatic t_command();
    wr(4'b0001, 32'h0000_00FF);
    chk("R2 ctl low byte", rd_data, 32'h0010_03F9);
    chk("R3 cc sets intx R8", {31'd0, intx}, 1);
    chk("R6 no msg in level mode", {31'd0, msg_pulse}, 0);
    wr(4'b0100, 32'h0010_0000);
    chk("R5 w1c cc", rd_data, 32'h0000_03F9);
    chk("R8 clear drops intx", {31'd0, intx}, 0);
  endtask

  task automatic t_lock();
    wr(4'b0010, 32'h0000_0F00);
    chk("R4 lock toggles, bit11 reads 0", rd_data, 32'h0090_03F9);
    chk("R8 intx up", {31'd0, intx}, 1);
    ev(0, 1, 1, 0);
    chk("R11 busy", {31'd0, plug_busy}, 1);
    chk("R11 status unchanged", rd_data, 32'h0090_03F9);
    @(negedge clk);
    chk("R11 busy one cycle", {31'd0, plug_busy}, 0);
    ev(0, 0, 0, 1);
    chk("R12 boot present", rd_data, 32'h00D0_03F9);
    wr(4'b0010, 32'h0000_0B00);
    chk("R4 unlock", rd_data, 32'h0050_03F9);
    wr(4'b1100, 32'hFFFF_0000);
    chk("R5 w1c all, presence kept", rd_data, 32'h0040_03F9);
    chk("R8 intx low", {31'd0, intx}, 0);
  endtask

  task automatic t_msg();
    msi_en = 1'b1; vec_in = 5'd19;
    ev(0, 1, 1, 0);
    chk("R10 insert", rd_data, 32'h0048_03F9);
    chk("R6 msi pulse", {31'd0, msg_pulse}, 1);
    chk("R6 msi kind", {31'd0, msg_msix}, 0);
    chk("R6 vector", {27'd0, msg_vec}, 32'd19);
    chk("R8 intx untouched", {31'd0, intx}, 0);
    @(negedge clk);
    chk("R6 one cycle", {31'd0, msg_pulse}, 0);
    ev(1, 0, 0, 0);
    chk("R7 new event no msg", {31'd0, msg_pulse}, 0);
    ev(1, 0, 0, 0);
    chk("R7 repeat event no msg", {31'd0, msg_pulse}, 0);
    chk("R7 status", rd_data, 32'h0049_03F9);
    msix_en = 1'b1; vec_in = 5'd7;
    wr(4'b0100, 32'h0009_0000);
    chk("R9 silent clear", {31'd0, msg_pulse}, 0);
    chk("R9 status", rd_data, 32'h0040_03F9);
    wr(4'b0001, 32'h0000_00F9);
    chk("R3 cmd msg", {31'd0, msg_pulse}, 1);
    chk("R6 msix priority", {31'd0, msg_msix}, 1);
    chk("R6 vector 7", {27'd0, msg_vec}, 32'd7);
    ev(0, 1, 0, 0);
    chk("R10 removal", rd_data, 32'h0018_03F9);
    chk("R7 removal no msg", {31'd0, msg_pulse}, 0);
  endtask

  task automatic t_order();
    wr(4'b1111, 32'h0018_03F9);
    chk("R13 clear before command", rd_data, 32'h0010_03F9);
    chk("R13 msg after reorder", {31'd0, msg_pulse}, 1);
    wr(4'b0000, 32'hFFFF_FFFF);
    chk("R13 no enables", rd_data, 32'h0010_03F9);
    chk("R13 no msg", {31'd0, msg_pulse}, 0);
    wr(4'b0001, 32'h0000_00D9);
    chk("R6 falling condition msg", {31'd0, msg_pulse}, 1);
    chk("R2 irq enable cleared", rd_data, 32'h0010_03D9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_command();
    t_lock();
    t_msg();
    t_order();
    msi_en = 0; msix_en = 0;
    do_reset();
    t_reset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule